// File: doc/BRIEF.md
# Address-Folded SEC-DED Protected SRAM

This block puts a single-port SRAM behind a 64-bit bus port. Each 64-bit array row holds two 32-bit words, and each word carries 7 check bits of its own. The check bits come from a Hamming SEC-DED code over the data word joined with the word's own address. The address is never stored. On a read the check bits are recomputed from the address that was asked for. If the array decoder selects the wrong row, the syndrome is nonzero and the read is reported as uncorrectable.

A read may fetch a byte, a halfword or a word, provided the access stays inside one 32-bit container. Requested bytes come back in their natural byte lanes of the 64-bit bus, and every other byte is zero. Only aligned 32-bit writes are accepted. Any other write, and any read that crosses a container, gets a bus error and leaves the array untouched. A configuration input adds one wait state to reads for fast clocks. Three fault inputs support self-test: one flips stored data bits, one flips stored check bits, and one flips row-select bits of the read.

Top module: `sram_ecc_addr`

## Requirements
- R1: While reset is held and after it is released, `ready` is 1 and `respValid`, `respErr`, `corrFlag` and `uncorrFlag` are 0.
- R2: A write with size 2 (word) and `addr[1:0]`=0 stores one 32-bit word, taken from `wdata[31:0]` when `addr[2]`=0 and from `wdata[63:32]` when `addr[2]`=1. A clean word read of that address returns the word in the same half of `rdata`, with the other half zero and both flags low.
- R3: A write is answered one cycle after acceptance with `respErr`=0. A write with size 0 (byte), 1 (half) or 3, or with `addr[1:0]`≠0, is answered with `respErr`=1 and leaves the stored data unchanged.
- R4: A read of size 0 at any offset, size 1 at offsets 0 to 2, or size 2 at offset 0 returns byte k of the addressed container on `rdata[32*addr[2] + 8*k +: 8]` for each byte k it covers, and zero on every other byte.
- R5: A read of size 1 at offset 3, size 2 at a nonzero offset, or size 3 is answered with `respErr`=1, `rdata`=0 and both flags low.
- R6: A request is accepted when `req` and `ready` are both 1, and `ready` stays 0 until its response cycle has ended. `respValid` is a one-cycle pulse. For writes, for errored requests and for reads with `waitSel`=0 (sampled at acceptance), it comes in the cycle right after acceptance. For a valid read with `waitSel`=1, it comes one cycle later.
- R7: A read whose stored data has one bit flipped returns the original data and raises `corrFlag` for the response cycle only, with `uncorrFlag` low.
- R8: A read whose stored check bits have one bit flipped, including the overall parity bit (bit 6 of `injChk`), returns the original data with `corrFlag` raised.
- R9: A read whose stored data has two bits flipped returns the stored (uncorrected) data and raises `uncorrFlag` with `corrFlag` low.
- R10: A read that fetches a correctly encoded word from a row other than the addressed one, through `faultRowXor`, raises `uncorrFlag` and never `corrFlag`, and returns the fetched data unchanged. This holds whether one or two word-address bits differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| waitSel | input | 1 | 1 adds one read wait state (fast clock) |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 9 | Byte address |
| size | input | 2 | 0 byte, 1 half, 2 word, 3 unsupported |
| wdata | input | 64 | Write data, word lane chosen by addr[2] |
| injData | input | 32 | Stored-data bit flips applied on write |
| injChk | input | 7 | Stored-check bit flips applied on write |
| faultRowXor | input | 6 | Row-select flips applied on read |
| ready | output | 1 | Block idle and able to accept |
| respValid | output | 1 | Response pulse |
| respErr | output | 1 | Bus error for an unsupported access |
| rdata | output | 64 | Read data in byte lanes, zero elsewhere |
| corrFlag | output | 1 | Single-bit error corrected |
| uncorrFlag | output | 1 | Uncorrectable error |

## Verification
The bench reads sub-word pieces at every legal offset and checks the lane placement. A design that shifted data to bit 0, or failed to zero unused bytes, would return wrong values. It tries each kind of illegal write and then reads the target word back, so a design that wrote partial words would be caught by the changed data. It flips a single data bit, a Hamming check bit and the overall parity bit, then a pair of data bits. Mistaking one pattern for the other would show up as wrong data or a wrong flag. It also reads from a neighbouring row whose word address differs in one bit and in two bits. A decoder that treated a single-bit syndrome at an address position as correctable would raise the wrong flag, or flip a data bit that was never in error.

// File: rtl/sram_ecc_pkg.sv
package sram_ecc_pkg;

  localparam int DATA_W  = 32;
  localparam int CHK_W   = 7;
  localparam int MSG_MAX = 57;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic respValid;
    logic respErr;
    logic dataValid;
  } ctrlStrobe_t;

  // Hamming positions 1..63 with check bits at powers of two; message bits
  // fill the remaining positions in ascending order. Bit 6 is overall parity.
  function automatic logic [CHK_W-1:0] eccEncode(input logic [MSG_MAX-1:0] msg);
    logic [CHK_W-1:0] c;
    int unsigned k;
    c = '0;
    k = 0;
    for (int p = 3; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int j = 0; j < 6; j++) begin
          if (p[j]) c[j] = c[j] ^ msg[k];
        end
        k++;
      end
    end
    c[6] = (^msg) ^ (^c[5:0]);
    return c;
  endfunction

  // Message index for a Hamming position; all ones for check positions.
  function automatic logic [6:0] posToIdx(input logic [5:0] pos);
    logic [6:0] r;
    int unsigned k;
    r = '1;
    k = 0;
    for (int p = 3; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (p == int'(pos)) r = 7'(k);
        k++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/sram_ecc_ctrl.sv
module sram_ecc_ctrl
  import sram_ecc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              waitSel,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              ready,
  output ctrlStrobe_t       strb,
  output logic [ADDR_W-1:0] accAddr,
  output logic [1:0]        accSize
);

  typedef enum logic [1:0] {PH_IDLE, PH_ACC, PH_WAIT} phase_e;

  phase_e phase;
  logic   accErr, accRead, slowQ;
  logic   accept, legalWr, legalRd, fitsRd, holdResp;

  always_comb begin
    accept  = req && (phase == PH_IDLE);
    legalWr = we && (size == SZ_WORD) && (addr[1:0] == 2'b00);
    case (size)
      SZ_BYTE: fitsRd = 1'b1;
      SZ_HALF: fitsRd = (addr[1:0] != 2'b11);
      SZ_WORD: fitsRd = (addr[1:0] == 2'b00);
      default: fitsRd = 1'b0;
    endcase
    legalRd  = !we && fitsRd;
    holdResp = (phase == PH_ACC) && accRead && slowQ;

    strb.wrEn      = accept && legalWr;
    strb.rdEn      = accept && legalRd;
    strb.respValid = ((phase == PH_ACC) && !holdResp) || (phase == PH_WAIT);
    strb.respErr   = strb.respValid && accErr;
    strb.dataValid = strb.respValid && accRead;
    ready          = (phase == PH_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      accErr  <= 1'b0;
      accRead <= 1'b0;
      slowQ   <= 1'b0;
      accAddr <= '0;
      accSize <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase   <= PH_ACC;
            accAddr <= addr;
            accSize <= size;
            accErr  <= we ? !legalWr : !legalRd;
            accRead <= legalRd;
            slowQ   <= waitSel;
          end
        end
        PH_ACC:  phase <= holdResp ? PH_WAIT : PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ecc_dpath.sv
module sram_ecc_dpath
  import sram_ecc_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int WADDR_W = ADDR_W - 2,
  localparam int ROW_W   = ADDR_W - 3,
  localparam int ROWS    = 1 << ROW_W,
  localparam int MSG_W   = DATA_W + WADDR_W,
  localparam int CELL_W  = DATA_W + CHK_W
) (
  input  logic               clk,
  input  ctrlStrobe_t        strb,
  input  logic [WADDR_W-1:0] reqWordAddr,
  input  logic [63:0]        wdata,
  input  logic [DATA_W-1:0]  injData,
  input  logic [CHK_W-1:0]   injChk,
  input  logic [ROW_W-1:0]   faultRowXor,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic [1:0]         accSize,
  output logic [63:0]        rdata,
  output logic               corrFlag,
  output logic               uncorrFlag
);

  logic [1:0][CELL_W-1:0] mem [ROWS];
  logic [1:0][CELL_W-1:0] rowQ;

  logic [ROW_W-1:0]   reqRow;
  logic               reqLane;
  logic [DATA_W-1:0]  wrWord;
  logic [MSG_MAX-1:0] wrMsg;
  logic [CHK_W-1:0]   wrChk;

  always_comb begin
    reqRow  = reqWordAddr[WADDR_W-1:1];
    reqLane = reqWordAddr[0];
    wrWord  = reqLane ? wdata[63:32] : wdata[31:0];
    wrMsg   = '0;
    wrMsg[DATA_W-1:0]     = wrWord;
    wrMsg[MSG_W-1:DATA_W] = reqWordAddr;
    wrChk   = eccEncode(wrMsg);
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[reqRow][reqLane] <= {wrChk ^ injChk, wrWord ^ injData};
    if (strb.rdEn) rowQ <= mem[reqRow ^ faultRowXor];
  end

  logic               accLane, dataOk, isCorr, isUncorr, chkPos;
  logic [WADDR_W-1:0] accWordAddr;
  logic [DATA_W-1:0]  rawWord, fixWord, outWord;
  logic [CHK_W-1:0]   rawChk, reChk, syn;
  logic [MSG_MAX-1:0] rdMsg;
  logic [5:0]         synPos;
  logic [6:0]         errIdx;
  logic [3:0]         baseMask, byteMask;

  always_comb begin
    accLane     = accAddr[2];
    accWordAddr = accAddr[ADDR_W-1:2];
    {rawChk, rawWord} = rowQ[accLane];
    rdMsg = '0;
    rdMsg[DATA_W-1:0]     = rawWord;
    rdMsg[MSG_W-1:DATA_W] = accWordAddr;
    reChk  = eccEncode(rdMsg);
    syn    = rawChk ^ reChk;
    synPos = syn[5:0];
    errIdx = posToIdx(synPos);
    chkPos = ((synPos & (synPos - 6'd1)) == 6'd0);

    isCorr   = 1'b0;
    isUncorr = 1'b0;
    fixWord  = rawWord;
    if (syn != '0) begin
      if (^syn) begin
        if (chkPos) begin
          isCorr = 1'b1;
        end else if (errIdx[6:5] == 2'b00) begin
          isCorr  = 1'b1;
          fixWord = rawWord ^ (32'd1 << errIdx[4:0]);
        end else begin
          isUncorr = 1'b1;          // syndrome lands on an address position
        end
      end else begin
        isUncorr = 1'b1;            // even weight: double error
      end
    end

    case (accSize)
      SZ_BYTE: baseMask = 4'b0001;
      SZ_HALF: baseMask = 4'b0011;
      SZ_WORD: baseMask = 4'b1111;
      default: baseMask = 4'b0000;
    endcase
    byteMask = baseMask << accAddr[1:0];

    outWord = isUncorr ? rawWord : fixWord;
    outWord = outWord & {{8{byteMask[3]}}, {8{byteMask[2]}},
                         {8{byteMask[1]}}, {8{byteMask[0]}}};

    dataOk     = strb.dataValid && strb.respValid && !strb.respErr;
    rdata      = '0;
    if (dataOk) rdata = accLane ? {outWord, 32'd0} : {32'd0, outWord};
    corrFlag   = dataOk && isCorr;
    uncorrFlag = dataOk && isUncorr;
  end

endmodule

// File: rtl/sram_ecc_addr.sv
module sram_ecc_addr
  import sram_ecc_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int ROW_W = ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              waitSel,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [63:0]       wdata,
  input  logic [31:0]       injData,
  input  logic [6:0]        injChk,
  input  logic [ROW_W-1:0]  faultRowXor,
  output logic              ready,
  output logic              respValid,
  output logic              respErr,
  output logic [63:0]       rdata,
  output logic              corrFlag,
  output logic              uncorrFlag
);

  ctrlStrobe_t       strb;
  logic [ADDR_W-1:0] accAddr;
  logic [1:0]        accSize;

  sram_ecc_ctrl #(.ADDR_W(ADDR_W)) ctrlI (
    .clk(clk), .rstN(rstN), .waitSel(waitSel), .req(req), .we(we),
    .addr(addr), .size(size), .ready(ready), .strb(strb),
    .accAddr(accAddr), .accSize(accSize)
  );

  sram_ecc_dpath #(.ADDR_W(ADDR_W)) dpathI (
    .clk(clk), .strb(strb), .reqWordAddr(addr[ADDR_W-1:2]), .wdata(wdata),
    .injData(injData), .injChk(injChk), .faultRowXor(faultRowXor),
    .accAddr(accAddr), .accSize(accSize), .rdata(rdata),
    .corrFlag(corrFlag), .uncorrFlag(uncorrFlag)
  );

  assign respValid = strb.respValid;
  assign respErr   = strb.respErr;

endmodule

// File: rtl/sram_ecc_addr_chk.sv
module sram_ecc_addr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        req,
  input logic        ready,
  input logic        respValid,
  input logic        respErr,
  input logic [63:0] rdata,
  input logic        corrFlag,
  input logic        uncorrFlag
);

  assert_err_in_resp_R5: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> respValid);

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> (rdata == 64'd0 && !corrFlag && !uncorrFlag));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(corrFlag && uncorrFlag));

  assert_flag_in_resp_R7: assert property (@(posedge clk) disable iff (!rstN)
    (corrFlag || uncorrFlag) |-> respValid);

  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (req && ready) |=> !ready);

  assert_resp_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  assert_resp_not_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !ready);

endmodule

bind sram_ecc_addr sram_ecc_addr_chk chkI (
  .clk(clk), .rstN(rstN), .req(req), .ready(ready), .respValid(respValid),
  .respErr(respErr), .rdata(rdata), .corrFlag(corrFlag), .uncorrFlag(uncorrFlag)
);

// File: tb/sram_ecc_addr_test.sv
`timescale 1ns/1ps
module sram_ecc_addr_test;

  logic        clk = 1'b0;
  logic        rstN, waitSel, req, we;
  logic [8:0]  addr;
  logic [1:0]  size;
  logic [63:0] wdata;
  logic [31:0] injData;
  logic [6:0]  injChk;
  logic [5:0]  faultRowXor;
  logic        ready, respValid, respErr, corrFlag, uncorrFlag;
  logic [63:0] rdata;

  always #2 clk = ~clk;

  sram_ecc_addr uut (
    .clk(clk), .rstN(rstN), .waitSel(waitSel), .req(req), .we(we),
    .addr(addr), .size(size), .wdata(wdata), .injData(injData),
    .injChk(injChk), .faultRowXor(faultRowXor), .ready(ready),
    .respValid(respValid), .respErr(respErr), .rdata(rdata),
    .corrFlag(corrFlag), .uncorrFlag(uncorrFlag)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic        gotErr, gotCorr, gotUncorr, earlyReady;
  logic [63:0] gotData;
  int          gotLat;

  typedef struct packed {
    logic        we;
    logic [8:0]  addr;
    logic [1:0]  size;
    logic [63:0] wdata;
    logic        expErr;
    logic [63:0] expData;
  } vec_t;

  localparam vec_t VECS [18] = '{
    '{1'b1, 9'h000, 2'd2, 64'h0000_0000_1122_3344, 1'b0, 64'h0},
    '{1'b1, 9'h004, 2'd2, 64'hA5B6_C7D8_0000_0000, 1'b0, 64'h0},
    '{1'b1, 9'h018, 2'd2, 64'h0000_0000_CAFE_F00D, 1'b0, 64'h0},
    '{1'b0, 9'h000, 2'd2, 64'h0, 1'b0, 64'h0000_0000_1122_3344},
    '{1'b0, 9'h004, 2'd2, 64'h0, 1'b0, 64'hA5B6_C7D8_0000_0000},
    '{1'b0, 9'h005, 2'd0, 64'h0, 1'b0, 64'h0000_C700_0000_0000},
    '{1'b0, 9'h001, 2'd1, 64'h0, 1'b0, 64'h0000_0000_0022_3300},
    '{1'b0, 9'h002, 2'd1, 64'h0, 1'b0, 64'h0000_0000_1122_0000},
    '{1'b0, 9'h01B, 2'd0, 64'h0, 1'b0, 64'h0000_0000_CA00_0000},
    '{1'b0, 9'h003, 2'd1, 64'h0, 1'b1, 64'h0},
    '{1'b0, 9'h002, 2'd2, 64'h0, 1'b1, 64'h0},
    '{1'b1, 9'h000, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0},
    '{1'b1, 9'h002, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0},
    '{1'b1, 9'h000, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0},
    '{1'b0, 9'h000, 2'd2, 64'h0, 1'b0, 64'h0000_0000_1122_3344},
    '{1'b0, 9'h000, 2'd3, 64'h0, 1'b1, 64'h0},
    '{1'b1, 9'h00C, 2'd2, 64'h0F0F_0F0F_DEAD_BEEF, 1'b0, 64'h0},
    '{1'b0, 9'h00C, 2'd2, 64'h0, 1'b0, 64'h0F0F_0F0F_0000_0000}
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge with the block idle; returns at a falling edge, idle again.
  task automatic access(input logic wSel, input logic w, input logic [8:0] a,
                        input logic [1:0] sz, input logic [63:0] wd,
                        input logic [31:0] iD, input logic [6:0] iC,
                        input logic [5:0] fx);
    waitSel = wSel; req = 1'b1; we = w; addr = a; size = sz; wdata = wd;
    injData = iD; injChk = iC; faultRowXor = fx;
    @(negedge clk);
    req = 1'b0; injData = '0; injChk = '0;
    earlyReady = ready;
    gotLat = 1;
    if (!respValid) begin
      @(negedge clk);
      gotLat = 2;
    end
    gotErr = respErr; gotData = rdata; gotCorr = corrFlag; gotUncorr = uncorrFlag;
    faultRowXor = '0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; waitSel = 1'b0; req = 1'b0; we = 1'b0; addr = '0; size = '0;
    wdata = '0; injData = '0; injChk = '0; faultRowXor = '0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 64'(ready), 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready", 64'(ready), 64'd1);
    check("R1 outputs idle", {60'd0, respValid, respErr, corrFlag, uncorrFlag}, 64'd0);

    for (int i = 0; i < 18; i++) begin
      string tag;
      vec_t v;
      v = VECS[i];
      if (v.we) tag = "R3";
      else if (v.expErr) tag = "R5";
      else if (v.size == 2'd2) tag = "R2";
      else tag = "R4";
      access(i[0], v.we, v.addr, v.size, v.wdata, 32'd0, 7'd0, 6'd0);
      check($sformatf("%s vec%0d err", tag, i), 64'(gotErr), 64'(v.expErr));
      check($sformatf("%s vec%0d data", tag, i), gotData, v.expData);
      check($sformatf("%s vec%0d flags", tag, i), {62'd0, gotCorr, gotUncorr}, 64'd0);
      check($sformatf("R6 vec%0d latency", i), 64'(gotLat),
            64'((i[0] && !v.we && !v.expErr) ? 2 : 1));
    end

    // R6: slow read keeps ready low through the wait cycle
    access(1'b1, 1'b0, 9'h000, 2'd2, 64'd0, 32'd0, 7'd0, 6'd0);
    check("R6 ready low during wait", 64'(earlyReady), 64'd0);
    check("R6 slow latency", 64'(gotLat), 64'd2);

    // R7: single data-bit flips, both lanes
    access(1'b0, 1'b1, 9'h020, 2'd2, 64'h0000_0000_1234_5678, 32'h0000_0020, 7'd0, 6'd0);
    access(1'b0, 1'b0, 9'h020, 2'd2, 64'd0, 32'd0, 7'd0, 6'd0);
    check("R7 data bit5", gotData, 64'h0000_0000_1234_5678);
    check("R7 flags bit5", {62'd0, gotCorr, gotUncorr}, 64'd2);
    access(1'b0, 1'b1, 9'h024, 2'd2, 64'h8765_4321_0000_0000, 32'h8000_0000, 7'd0, 6'd0);
    access(1'b1, 1'b0, 9'h024, 2'd2, 64'd0, 32'd0, 7'd0, 6'd0);
    check("R7 data bit31", gotData, 64'h8765_4321_0000_0000);
    check("R7 flags bit31", {62'd0, gotCorr, gotUncorr}, 64'd2);
    @(negedge clk);
    check("R7 flag is a pulse", {62'd0, corrFlag, uncorrFlag}, 64'd0);

    // R8: check-bit flips (Hamming bit and overall parity)
    access(1'b0, 1'b1, 9'h028, 2'd2, 64'h0000_0000_0BAD_C0DE, 32'd0, 7'h04, 6'd0);
    access(1'b0, 1'b0, 9'h028, 2'd2, 64'd0, 32'd0, 7'd0, 6'd0);
    check("R8 data chk2", gotData, 64'h0000_0000_0BAD_C0DE);
    check("R8 flags chk2", {62'd0, gotCorr, gotUncorr}, 64'd2);
    access(1'b0, 1'b1, 9'h02C, 2'd2, 64'h3C3C_5A5A_0000_0000, 32'd0, 7'h40, 6'd0);
    access(1'b0, 1'b0, 9'h02C, 2'd2, 64'd0, 32'd0, 7'd0, 6'd0);
    check("R8 data parity", gotData, 64'h3C3C_5A5A_0000_0000);
    check("R8 flags parity", {62'd0, gotCorr, gotUncorr}, 64'd2);

    // R9: double data-bit flip returns stored data
    access(1'b0, 1'b1, 9'h030, 2'd2, 64'h0000_0000_55AA_55AA, 32'h0000_0003, 7'd0, 6'd0);
    access(1'b0, 1'b0, 9'h030, 2'd2, 64'd0, 32'd0, 7'd0, 6'd0);
    check("R9 raw data", gotData, 64'h0000_0000_55AA_55A9);
    check("R9 flags", {62'd0, gotCorr, gotUncorr}, 64'd1);

    // R10: wrong-row fetches
    access(1'b0, 1'b1, 9'h040, 2'd2, 64'h0000_0000_0102_0304, 32'd0, 7'd0, 6'd0);
    access(1'b0, 1'b1, 9'h048, 2'd2, 64'h0000_0000_0A0B_0C0D, 32'd0, 7'd0, 6'd0);
    access(1'b0, 1'b1, 9'h058, 2'd2, 64'h0000_0000_7777_7777, 32'd0, 7'd0, 6'd0);
    access(1'b0, 1'b0, 9'h040, 2'd2, 64'd0, 32'd0, 7'd0, 6'd0);
    check("R10 clean baseline", {gotData[31:0], 30'd0, gotCorr, gotUncorr},
          {32'h0102_0304, 32'd0});
    access(1'b0, 1'b0, 9'h040, 2'd2, 64'd0, 32'd0, 7'd0, 6'd1);
    check("R10 one addr bit data", gotData, 64'h0000_0000_0A0B_0C0D);
    check("R10 one addr bit flags", {62'd0, gotCorr, gotUncorr}, 64'd1);
    access(1'b1, 1'b0, 9'h040, 2'd2, 64'd0, 32'd0, 7'd0, 6'd3);
    check("R10 two addr bits data", gotData, 64'h0000_0000_7777_7777);
    check("R10 two addr bits flags", {62'd0, gotCorr, gotUncorr}, 64'd1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule